// File: doc/BRIEF.md
# Dual Performance Counter Unit

This block gives a processor core two 32-bit event counters and one 32-bit control word, all reached through a small register port. On each clock the core presents single-cycle event pulses: one for each completed instruction and one generic pulse per counter. It also presents its current privilege level, an exception-level flag and an error-level flag. Each counter adds one when three things hold: its selected event pulse is present, the global enable is on, and the enable bit for the current privilege context is set for that counter.

Software selects what each counter watches with a 5-bit event code. Some codes switch a counter off. The error-level flag freezes both counters regardless of the settings. The overflow interrupt is a level signal. It is high whenever the top bit of either counter is set, and it stays high until software writes a value with that bit clear.

Top module: `perfmon_pair`

## Requirements
- R1: A synchronous active-high reset clears the control word and both counters to zero and leaves `ovf_irq` low.
- R2: While control bit 31 (global enable) is 0, neither counter changes except through a direct write.
- R3: While `err_level` is 1, neither counter increments, whatever the control word holds.
- R4: Counter k keeps four context enable bits at control bits 1+10k (exception), 2+10k (kernel), 3+10k (supervisor) and 4+10k (user). When `exc_level` is 1 the exception bit applies. Otherwise the kernel bit applies when `priv_mode`=00, the supervisor bit when it is 01, and the user bit when it is 10 or 11. A counter can increment only when the bit that applies is 1.
- R5: Counter k's event code is at control bits 9+10k:5+10k. Code 1 makes the counter add one in each cycle where `retire_pulse` is high.
- R6: Codes 2 to 14, and code 0 on counter 1, make counter k add one in each cycle where `evt_pulse[k]` is high.
- R7: Code 0 on counter 0, and codes 15 to 31 on either counter, stop that counter only. The other counter is not affected.
- R8: `ovf_irq` is high exactly while bit 31 of at least one counter is set. Once raised, it stays high until a register write clears that bit.
- R9: `reg_rdata` returns the register selected by `reg_idx` in the same cycle: 0 selects the control word, 1 selects counter 0 and 3 selects counter 1. Index 2 reads as zero and ignores writes. Control bits 0, 10 and 30:20 always read as zero.
- R10: In the cycle where the control word is written, increments still follow the old settings. The written settings apply from the next cycle onward.
- R11: A write to a counter's index loads `reg_wdata` into that counter. If an increment would occur in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| retire_pulse | input | 1 | One pulse per completed instruction |
| evt_pulse | input | 2 | Generic event pulse, one per counter |
| priv_mode | input | 2 | Privilege level: 00 kernel, 01 supervisor, 1x user |
| exc_level | input | 1 | Core is inside an exception handler |
| err_level | input | 1 | Core is at error level; all counting frozen |
| ovf_irq | output | 1 | Overflow interrupt, level sensitive |

## Verification
A pulse or a write applied in one cycle shows up in the counter register at the next rising edge. `ovf_irq` follows that same edge, because it is decoded directly from the counter registers. `reg_rdata` changes within the cycle in which `reg_idx` changes. The bench drives every stimulus 1 ns after a rising edge and samples 1 ns after the following edge. Reads are taken by changing `reg_idx` between edges. The main sweep runs every event code on each counter against every privilege context and every enable mask. Each case uses two retire-only cycles and one generic-only cycle, so the expected count tells apart which source was counted.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int DATA_W      = 32;
    localparam int EVT_W       = 5;
    localparam int NUM_CNT     = 2;
    localparam int IDX_W       = 2;
    localparam int SLOT_BASE   = 1;
    localparam int SLOT_STRIDE = 10;
    localparam int GLOB_BIT    = DATA_W - 1;

    localparam logic [EVT_W-1:0] EVT_RETIRE   = EVT_W'(1);
    localparam logic [EVT_W-1:0] EVT_FIRST_OFF = EVT_W'(15);
    localparam logic [EVT_W-1:0] EVT_ZERO     = '0;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'b00,
        PRIV_SUPER  = 2'b01,
        PRIV_USER   = 2'b10,
        PRIV_USER_B = 2'b11
    } priv_e;

    typedef struct packed {
        logic             exc_en;
        logic             krn_en;
        logic             sup_en;
        logic             usr_en;
        logic [EVT_W-1:0] evt_sel;
    } slot_cfg_t;

    typedef struct packed {
        logic                      glob_en;
        slot_cfg_t [NUM_CNT-1:0]   slot;
    } ctl_t;

    function automatic logic [DATA_W-1:0] ctl_pack(input ctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[GLOB_BIT] = c.glob_en;
        for (int k = 0; k < NUM_CNT; k++) begin
            w[SLOT_BASE + k*SLOT_STRIDE + 0]          = c.slot[k].exc_en;
            w[SLOT_BASE + k*SLOT_STRIDE + 1]          = c.slot[k].krn_en;
            w[SLOT_BASE + k*SLOT_STRIDE + 2]          = c.slot[k].sup_en;
            w[SLOT_BASE + k*SLOT_STRIDE + 3]          = c.slot[k].usr_en;
            w[SLOT_BASE + k*SLOT_STRIDE + 4 +: EVT_W] = c.slot[k].evt_sel;
        end
        return w;
    endfunction

    function automatic ctl_t ctl_unpack(input logic [DATA_W-1:0] w);
        ctl_t c;
        c.glob_en = w[GLOB_BIT];
        for (int k = 0; k < NUM_CNT; k++) begin
            c.slot[k].exc_en  = w[SLOT_BASE + k*SLOT_STRIDE + 0];
            c.slot[k].krn_en  = w[SLOT_BASE + k*SLOT_STRIDE + 1];
            c.slot[k].sup_en  = w[SLOT_BASE + k*SLOT_STRIDE + 2];
            c.slot[k].usr_en  = w[SLOT_BASE + k*SLOT_STRIDE + 3];
            c.slot[k].evt_sel = w[SLOT_BASE + k*SLOT_STRIDE + 4 +: EVT_W];
        end
        return c;
    endfunction

    function automatic logic ctx_allows(input slot_cfg_t s, input logic exc,
                                        input logic [1:0] priv);
        if (exc)
            return s.exc_en;
        case (priv_e'(priv))
            PRIV_KERNEL: return s.krn_en;
            PRIV_SUPER:  return s.sup_en;
            default:     return s.usr_en;
        endcase
    endfunction

endpackage

// File: rtl/perfmon_ctl_reg.sv
module perfmon_ctl_reg
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= ctl_unpack(wr_data);
    end

endmodule

// File: rtl/perfmon_gate.sv
module perfmon_gate
    import perfmon_pkg::*;
#(
    parameter int SLOT = 0
)(
    input  slot_cfg_t   cfg,
    input  logic        glob_en,
    input  logic        err_lvl,
    input  logic        exc_lvl,
    input  logic [1:0]  priv_mode,
    input  logic        retire_pulse,
    input  logic        evt_pulse,
    output logic        inc
);

    localparam bit ZERO_IS_OFF = (SLOT == 0);

    logic ctx_ok;
    logic code_ok;
    logic src;

    always_comb begin
        ctx_ok  = ctx_allows(cfg, exc_lvl, priv_mode);
        code_ok = (cfg.evt_sel < EVT_FIRST_OFF) &&
                  !(ZERO_IS_OFF && (cfg.evt_sel == EVT_ZERO));
        src     = (cfg.evt_sel == EVT_RETIRE) ? retire_pulse : evt_pulse;
        inc     = glob_en & ~err_lvl & ctx_ok & code_ok & src;
    end

endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              inc,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= ld_val;
        else if (inc)
            q <= q + DATA_W'(1);
    end

endmodule

// File: rtl/perfmon_pair.sv
module perfmon_pair
    import perfmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               retire_pulse,
    input  logic [NUM_CNT-1:0] evt_pulse,
    input  logic [1:0]         priv_mode,
    input  logic               exc_level,
    input  logic               err_level,
    output logic               ovf_irq
);

    localparam logic [IDX_W-1:0] CTL_IDX = '0;

    ctl_t                            ctl_q;
    logic                            ctl_glob;
    logic                            ctl_wr;
    logic [NUM_CNT-1:0]              cnt_ld;
    logic [NUM_CNT-1:0]              cnt_inc;
    logic [NUM_CNT-1:0][DATA_W-1:0]  cnt_q;
    logic [NUM_CNT-1:0]              cnt_msb;

    assign ctl_wr   = reg_we && (reg_idx == CTL_IDX);
    assign ctl_glob = ctl_q.glob_en;

    perfmon_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_wr),
        .wr_data (reg_wdata),
        .ctl_q   (ctl_q)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(2*g + 1);

        assign cnt_ld[g]  = reg_we && (reg_idx == MY_IDX);
        assign cnt_msb[g] = cnt_q[g][DATA_W-1];

        perfmon_gate #(.SLOT(g)) u_gate (
            .cfg          (ctl_q.slot[g]),
            .glob_en      (ctl_glob),
            .err_lvl      (err_level),
            .exc_lvl      (exc_level),
            .priv_mode    (priv_mode),
            .retire_pulse (retire_pulse),
            .evt_pulse    (evt_pulse[g]),
            .inc          (cnt_inc[g])
        );

        perfmon_counter u_counter (
            .clk    (clk),
            .rst    (rst),
            .ld     (cnt_ld[g]),
            .ld_val (reg_wdata),
            .inc    (cnt_inc[g]),
            .q      (cnt_q[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_idx == CTL_IDX)
            reg_rdata = ctl_pack(ctl_q);
        for (int k = 0; k < NUM_CNT; k++) begin
            if (reg_idx == IDX_W'(2*k + 1))
                reg_rdata = cnt_q[k];
        end
    end

    assign ovf_irq = |cnt_msb;

endmodule

// File: rtl/perfmon_pair_chk.sv
module perfmon_pair_chk
    import perfmon_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_we,
    input  logic [IDX_W-1:0]               reg_idx,
    input  logic [DATA_W-1:0]              reg_wdata,
    input  logic                           err_level,
    input  logic                           ctl_glob,
    input  logic                           ovf_irq,
    input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!ovf_irq && cnt_q[0] == '0 && cnt_q[1] == '0));

    p_glob_off_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl_glob && !reg_we) |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));

    p_err_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        (err_level && !reg_we) |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));

    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> ((cnt_q[0] - $past(cnt_q[0])) <= DATA_W'(1) &&
                     (cnt_q[1] - $past(cnt_q[1])) <= DATA_W'(1)));

    p_msb_raises_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(cnt_q[0][DATA_W-1]) || $rose(cnt_q[1][DATA_W-1])) |-> ovf_irq);

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_irq && !reg_we && cnt_q[0] != ALL_ONES && cnt_q[1] != ALL_ONES)
        |=> ovf_irq);

    p_load_cnt0_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == IDX_W'(1)) |=> (cnt_q[0] == $past(reg_wdata)));

    p_load_cnt1_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == IDX_W'(3)) |=> (cnt_q[1] == $past(reg_wdata)));

    p_idx2_inert_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == IDX_W'(2) && !ctl_glob)
        |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));

endmodule

bind perfmon_pair perfmon_pair_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .err_level (err_level),
    .ctl_glob  (ctl_glob),
    .ovf_irq   (ovf_irq),
    .cnt_q     (cnt_q)
);

// File: tb/perfmon_pair_test.sv
`timescale 1ns/1ps
module perfmon_pair_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        retire_pulse = 1'b0;
    logic [1:0]  evt_pulse = 2'b00;
    logic [1:0]  priv_mode = 2'b00;
    logic        exc_level = 1'b0;
    logic        err_level = 1'b0;
    logic        ovf_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    perfmon_pair uut (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .retire_pulse (retire_pulse),
        .evt_pulse    (evt_pulse),
        .priv_mode    (priv_mode),
        .exc_level    (exc_level),
        .err_level    (err_level),
        .ovf_irq      (ovf_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [1:0] idx, input logic [31:0] wd,
                        input bit ret, input bit e0, input bit e1);
        reg_we = we; reg_idx = idx; reg_wdata = wd;
        retire_pulse = ret; evt_pulse = {e1, e0};
        @(posedge clk); #1;
        reg_we = 0; retire_pulse = 0; evt_pulse = 2'b00;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        reg_idx = idx; #1; v = reg_rdata;
    endtask

    // control word: bit31 global; slot k at base 1+10k: exc,krn,sup,usr, then 5-bit code
    function automatic logic [31:0] mk_ctl(input bit glob, input int k, input logic [3:0] mask,
                                           input logic [4:0] code);
        logic [31:0] w;
        int b, ob;
        w = '0;
        w[31] = glob;
        b  = 1 + 10*k;
        ob = 1 + 10*(1-k);
        w[b +: 4]      = mask;
        w[b + 4 +: 5]  = code;
        w[ob +: 4]     = 4'hF;
        w[ob + 4 +: 5] = 5'd15;
        return w;
    endfunction

    // m: 0 exception, 1 kernel, 2 supervisor, 3 user; retire x2 + generic x1 applied
    function automatic logic [31:0] exp_cnt(input int k, input int code, input int m,
                                            input logic [3:0] mask);
        bit valid;
        valid = (code < 15) && !(k == 0 && code == 0);
        if (!valid || !mask[m]) return 32'd0;
        return (code == 1) ? 32'd2 : 32'd1;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] en0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        rd(2'd0, v); check("R1 ctl", v, 32'h0);
        rd(2'd1, v); check("R1 cnt0", v, 32'h0);
        rd(2'd3, v); check("R1 cnt1", v, 32'h0);
        check("R1 irq", {31'd0, ovf_irq}, 32'd0);

        // R9 reserved bits and index 2
        step(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);
        rd(2'd0, v); check("R9 ctl mask", v, 32'h800F_FBFE);
        step(1, 2'd1, 32'd5, 0, 0, 0);
        step(1, 2'd2, 32'h1234_5678, 0, 0, 0);
        rd(2'd2, v); check("R9 idx2 reads zero", v, 32'h0);
        rd(2'd1, v); check("R9 idx2 write ignored cnt0", v, 32'd5);
        rd(2'd3, v); check("R9 idx2 write ignored cnt1", v, 32'd0);
        rd(2'd0, v); check("R9 idx2 write ignored ctl", v, 32'h800F_FBFE);

        // R2 global enable off
        step(1, 2'd0, mk_ctl(0, 0, 4'hF, 5'd1), 0, 0, 0);
        step(1, 2'd1, 32'd0, 0, 0, 0);
        repeat (3) step(0, 2'd0, 0, 1, 1, 1);
        rd(2'd1, v); check("R2 no count when global off", v, 32'd0);

        // R3 error level freeze
        en0 = mk_ctl(1, 0, 4'hF, 5'd1);
        step(1, 2'd0, en0, 0, 0, 0);
        err_level = 1;
        repeat (3) step(0, 2'd0, 0, 1, 1, 1);
        rd(2'd1, v); check("R3 frozen under error level", v, 32'd0);
        err_level = 0;
        step(0, 2'd0, 0, 1, 0, 0);
        rd(2'd1, v); check("R3 resumes after error level", v, 32'd1);

        // R10 control write uses old settings in the write cycle
        step(1, 2'd0, 32'd0, 1, 0, 0);
        rd(2'd1, v); check("R10 old enable counts write cycle", v, 32'd2);
        step(0, 2'd0, 0, 1, 0, 0);
        rd(2'd1, v); check("R10 new disable applies next", v, 32'd2);
        step(1, 2'd0, en0, 1, 0, 0);
        rd(2'd1, v); check("R10 old disable holds write cycle", v, 32'd2);
        step(0, 2'd0, 0, 1, 0, 0);
        rd(2'd1, v); check("R10 new enable applies next", v, 32'd3);

        // R11 counter write beats increment
        step(1, 2'd1, 32'd100, 1, 0, 0);
        rd(2'd1, v); check("R11 load wins", v, 32'd100);
        step(0, 2'd0, 0, 1, 0, 0);
        rd(2'd1, v); check("R11 counts after load", v, 32'd101);

        // R8 overflow level
        step(1, 2'd1, 32'h7FFF_FFFE, 0, 0, 0);
        step(0, 2'd0, 0, 1, 0, 0);
        rd(2'd1, v); check("R8 below msb", v, 32'h7FFF_FFFF);
        check("R8 irq low", {31'd0, ovf_irq}, 32'd0);
        step(0, 2'd0, 0, 1, 0, 0);
        check("R8 irq rises at msb", {31'd0, ovf_irq}, 32'd1);
        repeat (4) step(0, 2'd0, 0, 1, 0, 0);
        check("R8 irq stays while counting", {31'd0, ovf_irq}, 32'd1);
        step(1, 2'd0, 32'd0, 0, 0, 0);
        repeat (2) step(0, 2'd0, 0, 0, 0, 0);
        check("R8 irq stays idle", {31'd0, ovf_irq}, 32'd1);
        step(1, 2'd1, 32'd5, 0, 0, 0);
        check("R8 irq drops on clear", {31'd0, ovf_irq}, 32'd0);
        step(1, 2'd3, 32'h8000_0000, 0, 0, 0);
        check("R8 irq from cnt1", {31'd0, ovf_irq}, 32'd1);
        step(1, 2'd3, 32'd0, 0, 0, 0);
        check("R8 irq cnt1 clear", {31'd0, ovf_irq}, 32'd0);

        // R4 priv 11 treated as user
        step(1, 2'd0, mk_ctl(1, 0, 4'b1000, 5'd1), 0, 0, 0);
        step(1, 2'd1, 32'd0, 0, 0, 0);
        priv_mode = 2'b11; exc_level = 0;
        step(0, 2'd0, 0, 1, 0, 0);
        rd(2'd1, v); check("R4 priv 11 uses user bit", v, 32'd1);

        // R4 R5 R6 R7 sweep
        for (int k = 0; k < 2; k++) begin
            for (int code = 0; code < 32; code++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int mask = 0; mask < 16; mask++) begin
                        exc_level = (m == 0);
                        priv_mode = (m == 1) ? 2'b00 : (m == 2) ? 2'b01 : 2'b10;
                        step(1, 2'd0, mk_ctl(1, k, 4'(mask), 5'(code)), 0, 0, 0);
                        step(1, 2'd1, 32'd0, 0, 0, 0);
                        step(1, 2'd3, 32'd0, 0, 0, 0);
                        step(0, 2'd0, 0, 1, 0, 0);
                        step(0, 2'd0, 0, 1, 0, 0);
                        step(0, 2'd0, 0, 0, 1, 1);
                        rd(k == 0 ? 2'd1 : 2'd3, v);
                        check($sformatf("R4/R5/R6/R7 k=%0d code=%0d ctx=%0d mask=%h",
                                        k, code, m, mask),
                              v, exp_cnt(k, code, m, 4'(mask)));
                        rd(k == 0 ? 2'd3 : 2'd1, v);
                        check($sformatf("R7 other slot off k=%0d code=%0d", k, code),
                              v, 32'd0);
                    end
                end
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule